// File: doc/BRIEF.md
# Packed Character Word Access Unit

This unit carries out single-character reads and writes on a memory whose only access size is a full 32-bit word. Four 8-bit characters share each word, and the first character of a string sits in the lowest byte. The caller supplies a base word address and an unsigned character index. The unit splits the index into a word offset, which is the index shifted right by two, and a byte lane, which is the two low index bits. It then talks to memory through a simple request/acknowledge word port.

A load reads one word and returns the selected character with zero extension. A store reads the word and substitutes the low byte of a source operand into the selected lane. It then writes the whole word back to the same address, so the other three bytes keep their values. Every accepted request ends with exactly one single-cycle `done` pulse. While a request is in flight, `busy` is high and any further requests are ignored.

Top module: `char_pack_unit`

## Requirements
- R1: After reset, `busy`, `done`, `mem_req` and `mem_we` are 0 and `load_data` is 0.
- R2: The memory word address is `req_base + (req_index >> 2)`, with `req_index` treated as unsigned and the sum wrapping modulo 2^32.
- R3: The byte lane is `req_index[1:0]`. Lane k occupies word bits 8k+7..8k, so index 0 selects bits 7..0.
- R4: A load places the selected character in `load_data[7:0]` and clears `load_data[31:8]`, even when the character's top bit is set.
- R5: A load makes exactly one memory read and no memory write.
- R6: A store makes one read followed by one write to the same address. The written word equals the word that was read, with only the selected lane replaced by `req_src[7:0]`.
- R7: Bits 31..8 of `req_src` have no effect on a store.
- R8: Each accepted request produces exactly one `done` pulse, which is high for one cycle. `busy` is low in that cycle.
- R9: `busy` is high from the cycle after acceptance until the `done` cycle. A `req_valid` seen while `busy` is high is ignored.
- R10: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` keep their values into the next cycle.
- R11: `load_data` changes only when a load completes, so a store leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a character access (taken only when not busy) |
| req_store | input | 1 | 1 = store character, 0 = load character |
| req_base | input | 32 | Base word address |
| req_index | input | 32 | Unsigned character index |
| req_src | input | 32 | Store source; only bits 7..0 are used |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| load_data | output | 32 | Zero-extended character from the last load |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Memory acknowledge; for reads, `mem_rdata` is valid in this cycle |
| mem_rdata | input | 32 | Read data |

## Verification
Several properties are checked on every cycle:
- the memory handshake holds still until it is acknowledged;
- a write phase only starts right after a read acknowledge, and keeps the read's address;
- `done` is a lone pulse that ends `busy`;
- the upper bits of `load_data` stay clear.

Other properties can only be shown by the directed scenarios, because they depend on comparing memory contents against values chosen in the bench:
- the word address and lane chosen for a given base and index, including a very large index;
- the exact merged word that a store writes;
- the read and write counts of each operation;
- the fact that requests issued while busy are dropped.

// File: rtl/char_pack_pkg.sv
package char_pack_pkg;

   typedef enum logic [1:0] {
      CP_IDLE  = 2'd0,
      CP_READ  = 2'd1,
      CP_WRITE = 2'd2
   } cp_state_t;

endpackage

// File: rtl/char_pack_addr.sv
// Splits a character index into a word offset and a lane, adds the base.
module char_pack_addr #(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 32,
   parameter int LANES  = 4
) (
   input  logic [ADDR_W-1:0]          base,
   input  logic [IDX_W-1:0]           index,
   output logic [ADDR_W-1:0]          word_addr,
   output logic [$clog2(LANES)-1:0]   lane
);
   localparam int LANE_W = $clog2(LANES);

   logic [IDX_W-1:0]  word_ofs;
   logic [ADDR_W-1:0] ofs_ext;

   // unsigned index: divide and modulo reduce to shift and mask
   assign word_ofs = index >> LANE_W;
   assign lane     = index[LANE_W-1:0];

   generate
      if (IDX_W >= ADDR_W) begin : g_trunc
         assign ofs_ext = word_ofs[ADDR_W-1:0];
      end else begin : g_zext
         assign ofs_ext = {{(ADDR_W-IDX_W){1'b0}}, word_ofs};
      end
   endgenerate

   assign word_addr = base + ofs_ext;

endmodule

// File: rtl/char_pack_extract.sv
// Selects one lane of a word and zero-extends it.
module char_pack_extract #(
   parameter int DATA_W = 32,
   parameter int CHAR_W = 8
) (
   input  logic [DATA_W-1:0]                  word,
   input  logic [$clog2(DATA_W/CHAR_W)-1:0]   lane,
   output logic [DATA_W-1:0]                  char_out
);
   localparam int LANES  = DATA_W / CHAR_W;
   localparam int LANE_W = $clog2(LANES);

   logic [CHAR_W-1:0] lane_chars [LANES];
   logic [CHAR_W-1:0] picked;

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         assign lane_chars[g] = word[g*CHAR_W +: CHAR_W];
      end
   endgenerate

   always_comb begin
      picked = lane_chars[0];
      for (int k = 1; k < LANES; k++) begin
         if (lane == LANE_W'(k)) picked = lane_chars[k];
      end
   end

   assign char_out = {{(DATA_W-CHAR_W){1'b0}}, picked};

endmodule

// File: rtl/char_pack_merge.sv
// Replaces one lane of a word with a new character.
module char_pack_merge #(
   parameter int DATA_W = 32,
   parameter int CHAR_W = 8
) (
   input  logic [DATA_W-1:0]                  word,
   input  logic [$clog2(DATA_W/CHAR_W)-1:0]   lane,
   input  logic [CHAR_W-1:0]                  new_char,
   output logic [DATA_W-1:0]                  merged
);
   localparam int LANES  = DATA_W / CHAR_W;
   localparam int LANE_W = $clog2(LANES);

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         assign merged[g*CHAR_W +: CHAR_W] =
            (lane == LANE_W'(g)) ? new_char : word[g*CHAR_W +: CHAR_W];
      end
   endgenerate

endmodule

// File: rtl/char_pack_unit.sv
module char_pack_unit
   import char_pack_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int CHAR_W = 8,
   parameter int IDX_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_store,
   input  logic [ADDR_W-1:0] req_base,
   input  logic [IDX_W-1:0]  req_index,
   input  logic [DATA_W-1:0] req_src,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] load_data,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata
);
   localparam int LANES  = DATA_W / CHAR_W;
   localparam int LANE_W = $clog2(LANES);

   generate
      if ((DATA_W % CHAR_W) != 0 || LANES < 2 || (1 << LANE_W) != LANES) begin : g_bad_geom
         $error("char_pack_unit: DATA_W/CHAR_W must be a power of two >= 2");
      end
      if (IDX_W < LANE_W) begin : g_bad_idx
         $error("char_pack_unit: IDX_W too small for lane select");
      end
   endgenerate

   cp_state_t         state_q;
   logic [ADDR_W-1:0] addr_q;
   logic [LANE_W-1:0] lane_q;
   logic              store_q;
   logic [CHAR_W-1:0] char_q;
   logic [DATA_W-1:0] word_q;
   logic [DATA_W-1:0] load_q;
   logic              done_q;

   logic [ADDR_W-1:0] calc_addr;
   logic [LANE_W-1:0] calc_lane;
   logic [DATA_W-1:0] ext_char;
   logic [DATA_W-1:0] new_word;
   logic              accept;

   char_pack_addr #(
      .ADDR_W (ADDR_W),
      .IDX_W  (IDX_W),
      .LANES  (LANES)
   ) u_addr (
      .base      (req_base),
      .index     (req_index),
      .word_addr (calc_addr),
      .lane      (calc_lane)
   );

   char_pack_extract #(
      .DATA_W (DATA_W),
      .CHAR_W (CHAR_W)
   ) u_extract (
      .word     (mem_rdata),
      .lane     (lane_q),
      .char_out (ext_char)
   );

   char_pack_merge #(
      .DATA_W (DATA_W),
      .CHAR_W (CHAR_W)
   ) u_merge (
      .word     (mem_rdata),
      .lane     (lane_q),
      .new_char (char_q),
      .merged   (new_word)
   );

   assign accept = req_valid && (state_q == CP_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= CP_IDLE;
         addr_q  <= '0;
         lane_q  <= '0;
         store_q <= 1'b0;
         char_q  <= '0;
         word_q  <= '0;
         load_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            CP_IDLE: begin
               if (accept) begin
                  addr_q  <= calc_addr;
                  lane_q  <= calc_lane;
                  store_q <= req_store;
                  char_q  <= req_src[CHAR_W-1:0];
                  state_q <= CP_READ;
               end
            end
            CP_READ: begin
               if (mem_ack) begin
                  if (store_q) begin
                     word_q  <= new_word;
                     state_q <= CP_WRITE;
                  end else begin
                     load_q  <= ext_char;
                     done_q  <= 1'b1;
                     state_q <= CP_IDLE;
                  end
               end
            end
            CP_WRITE: begin
               if (mem_ack) begin
                  done_q  <= 1'b1;
                  state_q <= CP_IDLE;
               end
            end
            default: state_q <= CP_IDLE;
         endcase
      end
   end

   assign busy      = (state_q != CP_IDLE);
   assign done      = done_q;
   assign load_data = load_q;
   assign mem_req   = (state_q == CP_READ) || (state_q == CP_WRITE);
   assign mem_we    = (state_q == CP_WRITE);
   assign mem_addr  = addr_q;
   assign mem_wdata = word_q;

endmodule

// File: rtl/char_pack_unit_chk.sv
module char_pack_unit_chk #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int CHAR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic [DATA_W-1:0] load_data,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic              mem_ack
);
   a_r10_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

   a_r6_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we) |-> ($past(mem_ack) && $past(mem_req) && !$past(mem_we)));

   a_r6_same_address: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we) |-> $stable(mem_addr));

   a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   a_r9_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   a_r9_req_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> busy);

   a_r4_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
      (load_data >> CHAR_W) == '0);

endmodule

bind char_pack_unit char_pack_unit_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .CHAR_W (CHAR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .done      (done),
   .load_data (load_data),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .mem_ack   (mem_ack)
);

// File: tb/char_pack_unit_tb.sv
module char_pack_unit_tb;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_store = 1'b0;
   logic [31:0] req_base = '0;
   logic [31:0] req_index = '0;
   logic [31:0] req_src = '0;
   logic        busy, done, mem_req, mem_we, mem_ack;
   logic [31:0] load_data, mem_addr, mem_wdata, mem_rdata;

   int checks = 0;
   int errors = 0;

   always #(CLK_P/2) clk = ~clk;

   char_pack_unit u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
      .req_base(req_base), .req_index(req_index), .req_src(req_src),
      .busy(busy), .done(done), .load_data(load_data),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   // word memory model: 64 words, acks after "stall" extra cycles
   logic [31:0] mem [64];
   logic        ack_q = 1'b0;
   logic [31:0] rdata_q = '0;
   int          stall = 0;
   int          wait_cnt = 0;
   int          rd_cnt = 0;
   int          wr_cnt = 0;
   int          unstable_cnt = 0;
   logic [31:0] last_addr = '0;
   logic        poke_en = 1'b0;
   logic [5:0]  poke_a = '0;
   logic [31:0] poke_d = '0;
   logic        pend_q = 1'b0;
   logic [31:0] pa_q = '0, pw_q = '0;
   logic        pwe_q = 1'b0;

   assign mem_ack   = ack_q;
   assign mem_rdata = rdata_q;

   always @(posedge clk) begin
      if (poke_en) mem[poke_a] <= poke_d;
      if (!rst_n) begin
         ack_q    <= 1'b0;
         wait_cnt <= 0;
         pend_q   <= 1'b0;
      end else begin
         ack_q <= 1'b0;
         if (pend_q && (!mem_req || mem_addr != pa_q || mem_we != pwe_q || mem_wdata != pw_q))
            unstable_cnt <= unstable_cnt + 1;
         pend_q <= mem_req && !ack_q;
         pa_q   <= mem_addr;
         pwe_q  <= mem_we;
         pw_q   <= mem_wdata;
         if (mem_req && !ack_q) begin
            if (wait_cnt >= stall) begin
               ack_q     <= 1'b1;
               wait_cnt  <= 0;
               last_addr <= mem_addr;
               if (mem_we) begin
                  mem[mem_addr[5:0]] <= mem_wdata;
                  wr_cnt <= wr_cnt + 1;
               end else begin
                  rdata_q <= mem[mem_addr[5:0]];
                  rd_cnt  <= rd_cnt + 1;
               end
            end else begin
               wait_cnt <= wait_cnt + 1;
            end
         end
      end
   end

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic poke(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      poke_en = 1'b1; poke_a = a; poke_d = d;
      @(negedge clk);
      poke_en = 1'b0;
   endtask

   // issue one request; optionally drive a conflicting request while busy
   task automatic run_op(input bit st, input logic [31:0] base, input logic [31:0] idx,
                         input logic [31:0] src, input bit intrude);
      int cyc;
      @(negedge clk);
      req_valid = 1'b1; req_store = st; req_base = base; req_index = idx; req_src = src;
      @(negedge clk);
      check(busy == 1'b1, "R9 busy after accept", {31'd0, busy}, 32'd1);
      if (intrude) begin
         req_valid = 1'b1; req_store = 1'b1; req_base = 32'd40; req_index = '0; req_src = 32'h5A;
         @(negedge clk);
      end
      req_valid = 1'b0;
      cyc = 0;
      while (!done && cyc < 50) begin
         @(negedge clk);
         cyc++;
      end
      check(done == 1'b1, "R8 done seen", {31'd0, done}, 32'd1);
      check(busy == 1'b0, "R8 busy low with done", {31'd0, busy}, 32'd0);
      @(negedge clk);
      check(done == 1'b0, "R8 done one cycle", {31'd0, done}, 32'd0);
   endtask

   task automatic t_reset();
      check(busy == 0 && done == 0 && mem_req == 0 && mem_we == 0, "R1 control idle",
            {28'd0, busy, done, mem_req, mem_we}, 32'd0);
      check(load_data == 0, "R1 load_data", load_data, 32'd0);
   endtask

   task automatic t_load_lanes();
      poke(6'd10, 32'h44332211);
      for (int k = 0; k < 4; k++) begin
         run_op(1'b0, 32'd10, 32'(k), 32'd0, 1'b0);
         check(load_data == 32'h11 * (k + 1), "R3 lane select", load_data, 32'h11 * (k + 1));
      end
   endtask

   task automatic t_zero_ext();
      poke(6'd11, 32'hF0E1D2C3);
      run_op(1'b0, 32'd11, 32'd3, 32'd0, 1'b0);
      check(load_data == 32'h000000F0, "R4 zero extension", load_data, 32'h000000F0);
   endtask

   task automatic t_address();
      int r0, w0;
      poke(6'd10, 32'hCAFE0077);
      r0 = rd_cnt; w0 = wr_cnt;
      run_op(1'b0, 32'd8, 32'd9, 32'd0, 1'b0);      // word 8+2, lane 1
      check(last_addr == 32'd10, "R2 word address", last_addr, 32'd10);
      check(load_data == 32'h00, "R3 lane 1 of word", load_data, 32'h00);
      check(rd_cnt - r0 == 1 && wr_cnt - w0 == 0, "R5 load one read no write",
            32'(((rd_cnt - r0) << 8) | (wr_cnt - w0)), 32'h100);
      poke(6'd5, 32'h00AB0000);
      run_op(1'b0, 32'd4, 32'h80000006, 32'd0, 1'b0); // unsigned: 4 + 0x20000001, lane 2
      check(last_addr == 32'h20000005, "R2 unsigned large index", last_addr, 32'h20000005);
      check(load_data == 32'hAB, "R3 lane 2 large index", load_data, 32'hAB);
   endtask

   task automatic t_store();
      int r0, w0;
      logic [31:0] keep;
      keep = load_data;
      poke(6'd20, 32'hAABBCCDD);
      r0 = rd_cnt; w0 = wr_cnt;
      run_op(1'b1, 32'd18, 32'd10, 32'h12345677, 1'b0); // word 20, lane 2
      check(mem[20] == 32'hAA77CCDD, "R6 merged word, R7 high src ignored", mem[20], 32'hAA77CCDD);
      check(rd_cnt - r0 == 1 && wr_cnt - w0 == 1, "R6 one read one write",
            32'(((rd_cnt - r0) << 8) | (wr_cnt - w0)), 32'h101);
      check(last_addr == 32'd20, "R6 write address", last_addr, 32'd20);
      check(load_data == keep, "R11 store keeps load_data", load_data, keep);
      for (int k = 0; k < 4; k++) begin
         poke(6'd21, 32'h01020304);
         run_op(1'b1, 32'd21, 32'(k), 32'hFFFFFF00 | 32'(8'hE0 + k), 1'b0);
         check(mem[21] == ((32'h01020304 & ~(32'hFF << (8 * k))) | (32'(8'hE0 + k) << (8 * k))),
               "R6 R7 store per lane", mem[21],
               (32'h01020304 & ~(32'hFF << (8 * k))) | (32'(8'hE0 + k) << (8 * k)));
      end
   endtask

   task automatic t_busy_ignore();
      int r0, w0;
      poke(6'd40, 32'h11111111);
      poke(6'd30, 32'h00009900);
      r0 = rd_cnt; w0 = wr_cnt;
      run_op(1'b0, 32'd30, 32'd1, 32'd0, 1'b1);
      check(load_data == 32'h99, "R9 original load result", load_data, 32'h99);
      check(mem[40] == 32'h11111111, "R9 intruding store dropped", mem[40], 32'h11111111);
      check(busy == 1'b0, "R9 no extra request started", {31'd0, busy}, 32'd0);
      check(rd_cnt - r0 == 1 && wr_cnt - w0 == 0, "R9 single access",
            32'(((rd_cnt - r0) << 8) | (wr_cnt - w0)), 32'h100);
   endtask

   task automatic t_stall();
      stall = 3;
      unstable_cnt = 0;
      poke(6'd50, 32'h55667788);
      run_op(1'b1, 32'd50, 32'd3, 32'h000000C3, 1'b0);
      check(mem[50] == 32'hC3667788, "R10 store under stall", mem[50], 32'hC3667788);
      run_op(1'b0, 32'd50, 32'd0, 32'd0, 1'b0);
      check(load_data == 32'h88, "R10 load under stall", load_data, 32'h88);
      check(unstable_cnt == 0, "R10 request held stable", 32'(unstable_cnt), 32'd0);
      stall = 0;
   endtask

   initial begin
      #(CLK_P * 100000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 64; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_load_lanes();
      t_zero_ext();
      t_address();
      t_store();
      t_busy_ignore();
      t_stall();
      repeat (2) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule